// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a fast reference clock into the timing strobes a UART needs. It emits a one-cycle oversample strobe at sixteen times the bit rate, plus a bit strobe on every sixteenth oversample strobe. The divisor is the reference frequency divided by sixteen times the baud rate. It has an integer part and a fraction counted in sixty-fourths. For example, a 48 MHz clock at 115200 baud gives an integer part of 26 and a fraction of 3.

A six-bit accumulator adds the fraction once per oversample period. When the addition carries out, that period is stretched by one clock. The strobe period therefore alternates between N and N+1 clocks, and its long-run average equals the programmed divisor exactly. Software writes both divisor parts through a small write port, normally while the block is disabled. A write made while running is picked up at the start of the next oversample period. Raising the enable restarts the counters and clears the accumulator.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset both divisor registers hold 0. Both strobes are low, and they stay low while nothing has been written, even with the enable high.
- R2: A write with `wr_sel`=0 loads the integer divisor from all of `wr_data`. A write with `wr_sel`=1 loads the fraction from `wr_data[5:0]`; the upper bits of `wr_data` have no effect on the fraction.
- R3: With fraction 0 and integer divisor N, the oversample strobe repeats every N clocks. With N=1 it is high on every cycle.
- R4: Period k after enable lasts N clocks, plus one when adding the fraction F to a six-bit accumulator (cleared at enable) carries out. The k-th strobe after enable therefore falls on cycle k*N + floor(k*F/64), and 64 periods take exactly 64*N+F clocks.
- R5: The first oversample strobe after enable is seen in the N-th cycle. Cycle 1 is the cycle that follows the first clock edge at which the enable is sampled high.
- R6: While the enable is low, both strobes stay low and all counters and the accumulator are cleared. A later rising enable restarts timing as in R5.
- R7: While the integer divisor is 0, no strobe is produced, whatever the fraction is.
- R8: A divisor written during a period does not change that period's length. It applies from the next period on.
- R9: The bit strobe is high only together with the oversample strobe, on the 16th, 32nd and later multiples of 16 oversample strobes after enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the generator when high; clears its timing state when low |
| wr_en | input | 1 | Divisor write strobe |
| wr_sel | input | 1 | 0 selects the integer divisor, 1 selects the fraction |
| wr_data | input | 16 | Write data; only bits 5:0 are used for the fraction |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with every 16th os_tick |

## Verification
The bench builds the block with its default parameters: a 16-bit integer, a 6-bit fraction and 16x oversampling. Small integer divisors of 0 to 6 keep periods short, so thousands of periods and many complete 64-period fraction cycles fit in a short run. They also reach the N=1 case, where the strobe is continuous, and the divisor-0 stall. The full fraction range of 0 to 63 reaches the longest carry patterns. A worked divisor of 26 with fraction 3 checks the 64-period total against the exact average.

// File: rtl/fbg_pkg.sv
// Package: shared defaults and the write-select encoding of the
// fractional baud generator.
package fbg_pkg;

    localparam int FBG_INT_W_DEF  = 16;
    localparam int FBG_FRAC_W_DEF = 6;
    localparam int FBG_OS_DEF     = 16;

    // Register chosen by the write port
    typedef enum logic {
        FBG_SEL_INT  = 1'b0,
        FBG_SEL_FRAC = 1'b1
    } fbg_sel_e;

endpackage

// File: rtl/fbg_div_regs.sv
// Divisor registers: hold the integer and fractional divisor written
// through the write port. Assumes FRAC_W <= INT_W; the fraction takes
// the low FRAC_W bits of the write data.
module fbg_div_regs
    import fbg_pkg::*;
#(
    parameter int INT_W  = FBG_INT_W_DEF,
    parameter int FRAC_W = FBG_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  fbg_sel_e          wr_sel,
    input  logic [INT_W-1:0]  wr_data,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac
);

    // Load the addressed divisor register on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_int  <= '0;
            div_frac <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                FBG_SEL_INT:  div_int  <= wr_data;
                FBG_SEL_FRAC: div_frac <= wr_data[FRAC_W-1:0];
                default:      div_int  <= div_int;
            endcase
        end
    end

endmodule

// File: rtl/fbg_period_gen.sv
// Period generator: counts oversample periods of div_int clocks and
// stretches a period by one clock whenever the fractional accumulator
// carries. Divisors are sampled only at a period boundary. A zero
// integer divisor holds the generator at the boundary with no strobe.
// Low enable clears the counter and the accumulator.
module fbg_period_gen
    import fbg_pkg::*;
#(
    parameter int INT_W  = FBG_INT_W_DEF,
    parameter int FRAC_W = FBG_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick_nxt,
    output logic              os_tick
);

    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0]  rem_q, rem_d;
    logic [FRAC_W-1:0] acc_q, acc_d;
    logic [FRAC_W:0]   acc_sum;
    logic [CNT_W-1:0]  len;
    logic              at_bound;
    logic              div_ok;
    logic              tick_d;

    assign at_bound = (rem_q == '0);
    assign div_ok   = (div_int != '0);
    assign acc_sum  = {1'b0, acc_q} + {1'b0, div_frac};
    assign len      = {1'b0, div_int} + CNT_W'(acc_sum[FRAC_W]);

    // Next counter, accumulator and strobe for this cycle
    always_comb begin
        rem_d  = rem_q;
        acc_d  = acc_q;
        tick_d = 1'b0;
        if (at_bound) begin
            if (div_ok) begin
                rem_d  = len - CNT_W'(1);
                acc_d  = acc_sum[FRAC_W-1:0];
                tick_d = (len == CNT_W'(1));
            end
        end else begin
            rem_d  = rem_q - CNT_W'(1);
            tick_d = (rem_q == CNT_W'(1));
        end
    end

    assign tick_nxt = enable & tick_d;

    // Register timing state; cleared by reset or by low enable
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            rem_q   <= '0;
            acc_q   <= '0;
            os_tick <= 1'b0;
        end else begin
            rem_q   <= rem_d;
            acc_q   <= acc_d;
            os_tick <= tick_d;
        end
    end

endmodule

// File: rtl/fbg_bit_div.sv
// Bit divider: counts oversample strobes and raises the bit strobe on
// every OS-th one, registered on the same edge as the oversample
// strobe. Assumes OS >= 2. Low enable restarts the count.
module fbg_bit_div
    import fbg_pkg::*;
#(
    parameter int OS = FBG_OS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick_nxt,
    output logic bit_tick
);

    localparam int SUB_W = $clog2(OS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);

    logic [SUB_W-1:0] sub_q;

    // Count oversample strobes within one bit time
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sub_q    <= '0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= tick_nxt && (sub_q == SUB_LAST);
            if (tick_nxt) begin
                sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
// Fractional baud generator top: divisor registers, period generator
// and bit divider. Assumes the divisors are normally rewritten while
// the enable is low; a write while running applies at the next period.
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int INT_W  = FBG_INT_W_DEF,
    parameter int FRAC_W = FBG_FRAC_W_DEF,
    parameter int OS     = FBG_OS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [INT_W-1:0] wr_data,
    output logic             os_tick,
    output logic             bit_tick
);

    logic [INT_W-1:0]  div_int_q;
    logic [FRAC_W-1:0] div_frac_q;
    logic              tick_nxt;
    fbg_sel_e          sel;

    assign sel = fbg_sel_e'(wr_sel);

    fbg_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_data  (wr_data),
        .div_int  (div_int_q),
        .div_frac (div_frac_q)
    );

    fbg_period_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .div_int  (div_int_q),
        .div_frac (div_frac_q),
        .tick_nxt (tick_nxt),
        .os_tick  (os_tick)
    );

    fbg_bit_div #(.OS(OS)) u_bitdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick_nxt (tick_nxt),
        .bit_tick (bit_tick)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
// Checker for frac_baud_gen: write port loading, quiet output while
// disabled, and bit strobe placement.
module frac_baud_gen_chk #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6,
    parameter int OS     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [INT_W-1:0]  wr_data,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              os_tick,
    input logic              bit_tick
);

    localparam int CW = $clog2(OS);

    logic [CW-1:0] os_cnt;

    // Count visible oversample strobes since enable
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            os_cnt <= '0;
        end else if (os_tick) begin
            os_cnt <= (os_cnt == CW'(OS - 1)) ? '0 : os_cnt + CW'(1);
        end
    end

    // R2: integer write lands in the integer register
    a_r2_int_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (div_int == $past(wr_data)));

    // R2: fraction write takes only the low bits
    a_r2_frac_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (div_frac == $past(wr_data[FRAC_W-1:0])));

    // R6: nothing is emitted after a low enable
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!os_tick && !bit_tick));

    // R9: bit strobe never stands alone
    a_r9_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R9: bit strobe falls on every OS-th oversample strobe
    a_r9_bit_place: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && os_tick) |-> (bit_tick == (os_cnt == CW'(OS - 1))));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .OS     (OS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .div_int  (div_int_q),
    .div_frac (div_frac_q),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

    localparam int INT_W  = 16;
    localparam int FRAC_W = 6;
    localparam int OS     = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n, enable, wr_en, wr_sel;
    logic [INT_W-1:0] wr_data;
    logic             os_tick, bit_tick;

    frac_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .OS(OS)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .os_tick(os_tick),
        .bit_tick(bit_tick)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    sh_int, sh_frac, m_acc, m_left, m_cnt;
    bit    m_bound;
    bit    exp_os, exp_bit;
    int    cyc_en = 0;
    int    os_seen = 0;
    string req = "R1";

    // Cycle of the n-th strobe after enable (R4 formula)
    function automatic int ticks_end(int di, int df, int n);
        return n * di + (n * df) / 64;
    endfunction

    task automatic chk(string r, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
        end
    endtask

    // One clock: update the expected strobes for the edge just passed, then compare
    task automatic step();
        int s;
        @(negedge clk);
        if (!rst_n) begin
            sh_int = 0; sh_frac = 0; m_bound = 1; m_acc = 0; m_left = 0;
            m_cnt = 0; exp_os = 0; exp_bit = 0;
        end else if (!enable) begin
            m_bound = 1; m_acc = 0; m_left = 0; m_cnt = 0;
            exp_os = 0; exp_bit = 0;
        end else begin
            if (m_bound) begin
                if (sh_int == 0) begin
                    exp_os = 0;
                end else begin
                    s      = m_acc + sh_frac;
                    m_left = sh_int + ((s >= 64) ? 1 : 0) - 1;
                    m_acc  = s % 64;
                    exp_os = (m_left == 0);
                    m_bound = exp_os;
                end
            end else begin
                m_left--;
                exp_os  = (m_left == 0);
                m_bound = exp_os;
            end
            exp_bit = 0;
            if (exp_os) begin
                exp_bit = (m_cnt == OS - 1);
                m_cnt   = (m_cnt + 1) % OS;
            end
        end
        if (rst_n && wr_en) begin
            if (wr_sel) sh_frac = int'(wr_data[FRAC_W-1:0]);
            else        sh_int  = int'(wr_data);
        end
        cyc_en = (rst_n && enable) ? cyc_en + 1 : 0;
        if (os_tick) os_seen++;
        chk({req, " os_tick"}, int'(os_tick), int'(exp_os));
        chk({req, " bit_tick"}, int'(bit_tick), int'(exp_bit));
    endtask

    task automatic write(bit sel, int data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data[INT_W-1:0];
        step();
        wr_en = 1'b0;
    endtask

    // Step until the n-th strobe since os_seen was cleared
    task automatic run_to(int n);
        for (int k = 0; k < 20000 && os_seen < n; k++) step();
    endtask

    // Program while disabled, enable, and time the n-th strobe
    task automatic measure(string r, int di, int fraw, int fexp, int n);
        req = r;
        enable = 1'b0;
        step();
        write(0, di);
        write(1, fraw);
        enable = 1'b1;
        os_seen = 0;
        run_to(n);
        chk({r, " n-th strobe cycle"}, cyc_en, ticks_end(di, fexp, n));
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        void'($urandom(32'h5eed));
        repeat (3) step();
        // R1: outputs low in reset
        chk("R1 reset os_tick", int'(os_tick), 0);
        chk("R1 reset bit_tick", int'(bit_tick), 0);
        rst_n = 1'b1;
        os_seen = 0;
        repeat (40) step();
        chk("R1 no strobes with reset divisors", os_seen, 0);

        // R7: zero integer divisor with nonzero fraction stays quiet
        req = "R7";
        write(1, 45);
        os_seen = 0;
        repeat (100) step();
        chk("R7 zero divisor strobes", os_seen, 0);

        // R3: integer-only periods
        measure("R3", 1, 0, 0, 20);
        measure("R3", 5, 0, 0, 10);

        // R4: fractional dithering, 64-period totals
        measure("R4", 3, 7, 7, 64);
        measure("R4", 26, 3, 3, 64);
        measure("R4", 2, 63, 63, 64);
        measure("R4", 1, 33, 33, 64);

        // R5: first strobe latency, then carry on the second period
        measure("R5", 4, 40, 40, 1);
        run_to(2);
        chk("R5 second strobe cycle", cyc_en, ticks_end(4, 40, 2));

        // R2: upper write bits ignored for the fraction (0xFFC5 -> 5)
        measure("R2", 2, 16'hFFC5, 5, 64);

        // R9: bit strobe on 16th and 32nd strobes
        measure("R9", 1, 0, 0, 16);
        chk("R9 bit_tick on 16th", int'(bit_tick), 1);
        measure("R9", 3, 0, 0, 32);
        chk("R9 bit_tick on 32nd", int'(bit_tick), 1);

        // R6: disable mid-period, then restart
        measure("R6", 3, 0, 0, 2);
        step();
        enable = 1'b0;
        os_seen = 0;
        repeat (10) step();
        chk("R6 strobes while disabled", os_seen, 0);
        enable = 1'b1;
        os_seen = 0;
        run_to(1);
        chk("R6 restart first strobe cycle", cyc_en, 3);

        // R8: change during a period applies to the next one
        measure("R8", 4, 0, 0, 1);
        step();
        write(0, 7);
        run_to(2);
        chk("R8 current period kept", cyc_en, 8);
        run_to(3);
        chk("R8 next period uses new divisor", cyc_en, 15);

        // Random mix of writes and enable toggles against the model
        req = "R8 random";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2)       begin enable = ~enable; step(); end
            else if (r < 6)  write(0, int'($urandom % 7));
            else if (r < 10) write(1, int'($urandom));
            else             step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule